// File: doc/BRIEF.md
# Prioritized Rectangular Window Compositor

This block sits in the background path of an on-screen display. A display engine walks a character grid and gives it the current row and column. For each cell, the block decides whether one of four rectangular background windows covers it. If a window covers the cell, the block reports that window's 3-bit colour, its intensity select and its shadow enable. If several windows cover the cell, the lowest-numbered one wins.

The windows are set up through a byte-wide write port into twelve configuration bytes, three per window. The priority decision is registered, so the outputs for a cell appear one clock after its coordinates are presented.

Top module: `win_compositor`

## Requirements
- R1: While reset is applied and after it is released, every window is disabled, every configuration field is zero and all outputs read 0 until configuration is written.
- R2: Window k (k = 0..3, 0 is the highest priority) owns bytes 3k, 3k+1 and 3k+2. The layout of each byte is:
  - byte 3k: row start in bits [7:4], row end in bits [3:0];
  - byte 3k+1: column start in bits [7:4], column end in bits [3:0];
  - byte 3k+2: enable in bit 5, intensity in bit 4, shadow in bit 3, RGB in bits [2:0], bits [7:6] ignored.
  
  A write with wr_en high is applied at the clock edge, and the next cell decision uses it.
- R3: A window covers a cell when row start ≤ row ≤ row end and column start ≤ col ≤ column end, with both bounds inclusive.
- R4: A window whose enable bit is 0 never covers any cell.
- R5: A window whose row start exceeds its row end, or whose column start exceeds its column end, covers no cell. Such a window never wraps around the edge of the grid.
- R6: Where several enabled windows cover a cell, the colour, intensity and shadow of the lowest-numbered one are output.
- R7: When no enabled window covers the cell, win_active, win_rgb, win_int and win_shadow are all 0.
- R8: The outputs for the row and column sampled at one clock edge appear after that edge and hold for one cycle.
- R9: Writes to addresses 12 to 15 change no window configuration.
- R10: The output colour, intensity and shadow are the winning window's stored RGB, intensity and shadow bits, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Configuration byte write strobe |
| wr_addr | input | 4 | Configuration byte address |
| wr_data | input | 8 | Configuration byte value |
| row | input | 4 | Current character row |
| col | input | 4 | Current character column |
| win_active | output | 1 | A window covers the cell |
| win_rgb | output | 3 | Colour of the winning window |
| win_int | output | 1 | Intensity select of the winning window |
| win_shadow | output | 1 | Shadow enable of the winning window |

## Verification
The bench sweeps every cell of the grid against rectangles that touch their own bounds. A design with exclusive or shifted comparisons would lose or gain a border row or column. Windows whose start equals their end must show exactly one line, while windows whose start exceeds their end must stay blank. A design that wraps around the grid would paint the complement of such a window. Stacks of overlapping windows with distinct colours expose a reversed or broken priority chain, because the wrong colour appears in the overlap. Writes to the unused addresses, disabled windows and random reconfiguration in the middle of a scan catch address aliasing, a missing enable gate and an extra or missing pipeline stage.

// File: rtl/win_pkg.sv
package win_pkg;
  localparam int NWIN     = 4;
  localparam int POS_W    = 4;
  localparam int RGB_W    = 3;
  localparam int BYTES_PW = 3;
  localparam int NBYTES   = NWIN * BYTES_PW;
  localparam int ADDR_W   = $clog2(NBYTES + 1);

  typedef struct packed {
    logic             en;
    logic             inten;
    logic             shadow;
    logic [RGB_W-1:0] rgb;
    logic [POS_W-1:0] row_lo;
    logic [POS_W-1:0] row_hi;
    logic [POS_W-1:0] col_lo;
    logic [POS_W-1:0] col_hi;
  } win_cfg_t;

  typedef struct packed {
    logic             active;
    logic [RGB_W-1:0] rgb;
    logic             inten;
    logic             shadow;
  } win_pix_t;
endpackage

// File: rtl/win_cfg_regs.sv
module win_cfg_regs
  import win_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_sn,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [7:0]             wr_data,
  output win_cfg_t [NWIN-1:0]    cfg
);
  for (genvar k = 0; k < NWIN; k++) begin : g_win
    localparam logic [ADDR_W-1:0] A_ROW  = ADDR_W'(BYTES_PW * k);
    localparam logic [ADDR_W-1:0] A_COL  = ADDR_W'(BYTES_PW * k + 1);
    localparam logic [ADDR_W-1:0] A_ATTR = ADDR_W'(BYTES_PW * k + 2);

    logic [7:0] row_q, col_q;
    logic [5:0] attr_q;
    logic       row_ce, col_ce, attr_ce;

    always_comb begin
      row_ce  = wr_en && (wr_addr == A_ROW);
      col_ce  = wr_en && (wr_addr == A_COL);
      attr_ce = wr_en && (wr_addr == A_ATTR);
    end

    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) begin
        row_q  <= '0;
        col_q  <= '0;
        attr_q <= '0;
      end else begin
        if (row_ce)  row_q  <= wr_data;
        if (col_ce)  col_q  <= wr_data;
        if (attr_ce) attr_q <= wr_data[5:0];
      end
    end

    always_comb begin
      cfg[k].en     = attr_q[5];
      cfg[k].inten  = attr_q[4];
      cfg[k].shadow = attr_q[3];
      cfg[k].rgb    = attr_q[2:0];
      cfg[k].row_lo = row_q[7:4];
      cfg[k].row_hi = row_q[3:0];
      cfg[k].col_lo = col_q[7:4];
      cfg[k].col_hi = col_q[3:0];
    end
  end
endmodule

// File: rtl/win_cover.sv
module win_cover
  import win_pkg::*;
(
  input  win_cfg_t [NWIN-1:0] cfg,
  input  logic [POS_W-1:0]    row,
  input  logic [POS_W-1:0]    col,
  output logic [NWIN-1:0]     hit
);
  for (genvar k = 0; k < NWIN; k++) begin : g_cmp
    logic in_rows, in_cols;
    always_comb begin
      in_rows = (row >= cfg[k].row_lo) && (row <= cfg[k].row_hi);
      in_cols = (col >= cfg[k].col_lo) && (col <= cfg[k].col_hi);
      hit[k]  = cfg[k].en && in_rows && in_cols;
    end
  end
endmodule

// File: rtl/win_select.sv
module win_select
  import win_pkg::*;
(
  input  logic                clk,
  input  logic                rst_sn,
  input  win_cfg_t [NWIN-1:0] cfg,
  input  logic [NWIN-1:0]     hit,
  output win_pix_t            pix_q
);
  win_pix_t pix_d;

  always_comb begin
    pix_d = '0;
    for (int k = NWIN - 1; k >= 0; k--) begin
      if (hit[k]) begin
        pix_d.active = 1'b1;
        pix_d.rgb    = cfg[k].rgb;
        pix_d.inten  = cfg[k].inten;
        pix_d.shadow = cfg[k].shadow;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pix_q <= '0;
    else         pix_q <= pix_d;
  end
endmodule

// File: rtl/win_compositor.sv
module win_compositor
  import win_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [POS_W-1:0]     row,
  input  logic [POS_W-1:0]     col,
  output logic                 win_active,
  output logic [RGB_W-1:0]     win_rgb,
  output logic                 win_int,
  output logic                 win_shadow
);
  logic [1:0]          rst_pipe;
  logic                rst_sn;
  win_cfg_t [NWIN-1:0] cfg;
  logic [NWIN-1:0]     hit;
  win_pix_t            pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  win_cfg_regs u_regs (
    .clk(clk), .rst_sn(rst_sn), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg)
  );

  win_cover u_cover (.cfg(cfg), .row(row), .col(col), .hit(hit));

  win_select u_sel (
    .clk(clk), .rst_sn(rst_sn), .cfg(cfg), .hit(hit), .pix_q(pix)
  );

  assign win_active = pix.active;
  assign win_rgb    = pix.rgb;
  assign win_int    = pix.inten;
  assign win_shadow = pix.shadow;
endmodule

// File: rtl/win_comp_checker.sv
module win_comp_checker
  import win_pkg::*;
(
  input logic                clk,
  input logic                rst_sn,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input win_cfg_t [NWIN-1:0] cfg,
  input logic [NWIN-1:0]     hit,
  input logic                win_active,
  input logic [RGB_W-1:0]    win_rgb,
  input logic                win_int,
  input logic                win_shadow
);
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    !win_active |-> (win_rgb == '0 && !win_int && !win_shadow));

  p_hit_shows_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (|hit) |=> win_active);

  p_nohit_blank_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    !(|hit) |=> !win_active);

  p_top_wins_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    hit[0] |=> (win_rgb == $past(cfg[0].rgb) && win_int == $past(cfg[0].inten)
                && win_shadow == $past(cfg[0].shadow)));

  p_hole_addr_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && wr_addr >= ADDR_W'(NBYTES)) |=> $stable(cfg));

  for (genvar k = 0; k < NWIN; k++) begin : g_k
    p_inverted_blank_r5: assert property (@(posedge clk) disable iff (!rst_sn)
      (cfg[k].row_lo > cfg[k].row_hi || cfg[k].col_lo > cfg[k].col_hi) |-> !hit[k]);
    p_disabled_blank_r4: assert property (@(posedge clk) disable iff (!rst_sn)
      !cfg[k].en |-> !hit[k]);
  end
endmodule

bind win_compositor win_comp_checker u_chk (
  .clk(clk), .rst_sn(rst_sn), .wr_en(wr_en), .wr_addr(wr_addr), .cfg(cfg),
  .hit(hit), .win_active(win_active), .win_rgb(win_rgb), .win_int(win_int),
  .win_shadow(win_shadow)
);

// File: tb/win_compositor_test.sv
module win_compositor_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] row = '0, col = '0;
  logic       win_active, win_int, win_shadow;
  logic [2:0] win_rgb;

  int  n_tests = 0, n_fail = 0;
  bit  chk_on = 1'b0, done = 1'b0;
  string tag = "R1";

  // reference model state
  logic [7:0] mem [12];
  logic       e_act, e_int, e_sh;
  logic [2:0] e_rgb;

  always #5 clk = ~clk;

  win_compositor uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .row(row), .col(col), .win_active(win_active), .win_rgb(win_rgb),
    .win_int(win_int), .win_shadow(win_shadow)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mem[i]) mem[i] = 8'h00;
      e_act = 0; e_rgb = 0; e_int = 0; e_sh = 0;
    end else begin
      e_act = 0; e_rgb = 0; e_int = 0; e_sh = 0;
      for (int w = 3; w >= 0; w--) begin
        int rl, rh, cl, ch;
        rl = mem[3*w][7:4];   rh = mem[3*w][3:0];
        cl = mem[3*w+1][7:4]; ch = mem[3*w+1][3:0];
        if (mem[3*w+2][5] && row >= rl && row <= rh && col >= cl && col <= ch) begin
          e_act = 1; e_rgb = mem[3*w+2][2:0];
          e_int = mem[3*w+2][4]; e_sh = mem[3*w+2][3];
        end
      end
      if (wr_en && wr_addr < 12) mem[wr_addr] = wr_data;
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      n_tests++;
      if ({win_active, win_rgb, win_int, win_shadow} !== {e_act, e_rgb, e_int, e_sh}) begin
        n_fail++;
        $display("FAIL %s t=%0t act/rgb/int/sh actual=%b/%0d/%b/%b expected=%b/%0d/%b/%b",
                 tag, $time, win_active, win_rgb, win_int, win_shadow, e_act, e_rgb, e_int, e_sh);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic win(input int k, input logic [7:0] r, input logic [7:0] c, input logic [7:0] at);
    wr(4'(3*k), r); wr(4'(3*k+1), c); wr(4'(3*k+2), at);
  endtask

  task automatic scan();
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        @(negedge clk); row = 4'(r); col = 4'(c);
      end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    n_tests++;
    if ({win_active, win_rgb, win_int, win_shadow} !== 6'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs actual=%b expected=0", {win_active, win_rgb, win_int, win_shadow});
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_on = 1;
    scan();                                   // R1 R7: nothing enabled
    tag = "R2_R10";
    win(2, 8'h0F, 8'h0F, 8'b00_1_1_0_101);    // full grid, rgb 5, int 1
    scan();
    tag = "R3";
    win(0, 8'h25, 8'h37, 8'b00_1_0_1_011);    // rows 2..5, cols 3..7
    scan();
    tag = "R6";
    win(1, 8'h48, 8'h59, 8'b00_1_1_1_110);
    win(3, 8'h0F, 8'h0F, 8'b00_1_0_0_001);
    scan();
    tag = "R4";
    wr(4'd2, 8'b00_0_1_1_111);                // disable window 0
    wr(4'd8, 8'b00_0_1_0_101);                // disable window 2
    scan();
    tag = "R5";
    win(1, 8'h73, 8'h0F, 8'b00_1_1_0_010);    // rows inverted
    win(0, 8'h0F, 8'hC2, 8'b00_1_0_1_100);    // cols inverted
    win(3, 8'h66, 8'h99, 8'b00_1_1_1_111);    // single cell 6,9
    scan();
    tag = "R9";
    win(2, 8'h1E, 8'h2D, 8'b00_1_0_1_011);
    for (int a = 12; a < 16; a++) wr(4'(a), 8'hFF);
    scan();
    tag = "R8_R2";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      row = 4'($urandom); col = 4'($urandom);
      wr_en = ($urandom % 3) == 0;
      wr_addr = 4'($urandom); wr_data = 8'($urandom);
    end
    @(negedge clk); wr_en = 0;
    tag = "R7";
    for (int k = 0; k < 4; k++) wr(4'(3*k+2), 8'h00);
    scan();
    @(negedge clk);
    finish_run();
  end
endmodule